// File: doc/BRIEF.md
# Clear-Engine Trigger and Status Controller

This block sits between a management processor and a set of independent hardware clear engines, one engine per system domain. Firmware starts engines by writing a trigger register. A hardware request input can start them too, but only while a safety-gate bit allows it. Each engine returns a completion line and a pass/fail line. The completion line drops when the engine starts and rises when it finishes. The controller exposes both lines through read-only registers and turns each rising completion edge into a sticky interrupt-pending bit.

Firmware may also keep a running error record in an error-log register. That register accepts writes only while a second safety-gate bit is set. The normal reset does not clear it; only the power-on reset does.

Engine lanes sit at fixed bit positions, and every register uses the same positions:
- bits 0 to 3: application processor cores 0 to 3
- bits 6 and 7: pixel processors 0 and 1
- bit 10: the real-time processor
- bits 12 and 13: USB controllers 0 and 1
- bit 16: the rest of the low-power domain
- bit 17: the rest of the full-power domain

All other bit positions are reserved.

Top module: `clr_eng_ctrl`

## Requirements
- R1: Writing the trigger register (address 0) with a 1 in the bit of an idle engine lane produces a single-cycle pulse on that bit of eng_start_o. The pulse appears in the clock cycle after the write. The trigger register always reads 0.
- R2: The acknowledge register (address 1) reads the current eng_done_i value on the engine lanes in the same cycle, with no register stage.
- R3: The result register (address 2) reads the current eng_pass_i value on the engine lanes in the same cycle.
- R4: A 0-to-1 change on an engine lane of eng_done_i sets that lane's bit in the pending register (address 3) one cycle later. irq_o is 1 exactly when at least one pending bit is set.
- R5: Writing a 1 to a bit of the pending register clears that bit, and writing a 0 leaves it unchanged. If a rising completion edge and a clear of the same bit fall in the same cycle, the bit stays set.
- R6: A lane of hw_trig_i starts an idle engine only while gate bit 0 (hardware-trigger enable) of the gate register (address 4) is 1. While that bit is 0, hw_trig_i has no effect.
- R7: The error-log register (address 5) takes a write only while gate bit 1 (log-write enable) is 1. Otherwise it keeps its value.
- R8: The error-log register keeps its value through rst_ni. It returns to 0 only on por_ni.
- R9: Reserved bit positions read as 0 in every register, and a 1 written to them starts nothing. The gate register holds only bits 1:0.
- R10: A start request is ignored for a lane whose eng_done_i is 0. It is also ignored for a lane whose start pulse is being driven in the current cycle. Either way, no second pulse is issued.
- R11: After reset, eng_start_o is 0, irq_o is 0, and the pending and gate registers read 0. After power-on reset, the error log also reads 0.

Ports table notes: the Width column for engine-lane ports is the number of lanes, which is 18 with the default parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset for everything except the error log |
| por_ni | input | 1 | Active-low asynchronous power-on reset for the error log |
| bus_we_i | input | 1 | Single-cycle register write strobe |
| bus_addr_i | input | AW (3) | Register word address |
| bus_wdata_i | input | DW (32) | Write data |
| bus_rdata_o | output | DW (32) | Read data, combinational from the address |
| hw_trig_i | input | LANES (18) | Hardware start request per lane |
| eng_start_o | output | LANES (18) | Single-cycle start pulse per engine |
| eng_done_i | input | LANES (18) | Engine completion line: 1 when idle, 0 while busy |
| eng_pass_i | input | LANES (18) | Engine pass/fail result |
| irq_o | output | 1 | OR of all pending completion bits |

## Verification
The start logic is tried three ways:
- Random trigger masks hit engines that are idle, engines that are still busy, and reserved positions. This separates correct gating on eng_done_i from a controller that pulses every requested bit.
- Back-to-back writes and a held hardware request test the in-flight block separately from the busy block.
- Hardware requests are sent with the trigger gate open and with it closed.

Completion tracking runs against engine models with random delays. Pending bits are compared after every batch. A directed case puts a rising edge and a write-one-to-clear in the same cycle. The error log is exercised across a gated write, an open write, a normal reset and a power-on reset, which separates the two reset domains.

// File: rtl/clr_pkg.sv
package clr_pkg;
  localparam int LANES_DEF = 18;
  localparam int DW_DEF    = 32;
  localparam int AW_DEF    = 3;
  // engine lanes: cores 0-3, pixel 6-7, rt proc 10, usb 12-13, lp 16, fp 17
  localparam logic [LANES_DEF-1:0] LANE_MASK_DEF = 18'h334CF;

  localparam int ADDR_TRIG = 0;
  localparam int ADDR_ACK  = 1;
  localparam int ADDR_RES  = 2;
  localparam int ADDR_PEND = 3;
  localparam int ADDR_GATE = 4;
  localparam int ADDR_LOG  = 5;

  localparam int GATE_HW_BIT  = 0;
  localparam int GATE_LOG_BIT = 1;
  localparam int GATE_W       = 2;
endpackage

// File: rtl/clr_start_gen.sv
module clr_start_gen #(
  parameter int              LANES     = clr_pkg::LANES_DEF,
  parameter logic [LANES-1:0] LANE_MASK = clr_pkg::LANE_MASK_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_we_i,
  input  logic [LANES-1:0] sw_bits_i,
  input  logic [LANES-1:0] hw_trig_i,
  input  logic             hw_en_i,
  input  logic [LANES-1:0] done_i,
  output logic [LANES-1:0] start_o
);
  logic [LANES-1:0] req;
  logic [LANES-1:0] start_q;

  // busy (done low) or pulse already in flight blocks a new start
  always_comb begin
    req = (sw_we_i ? sw_bits_i : '0) | (hw_en_i ? hw_trig_i : '0);
    req = req & LANE_MASK & done_i & ~start_q;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (LANE_MASK[i]) begin : g_eng
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) start_q[i] <= 1'b0;
        else         start_q[i] <= req[i];
      end
    end else begin : g_rsv
      assign start_q[i] = 1'b0;
    end
  end

  assign start_o = start_q;
endmodule

// File: rtl/clr_irq_track.sv
module clr_irq_track #(
  parameter int               LANES     = clr_pkg::LANES_DEF,
  parameter logic [LANES-1:0] LANE_MASK = clr_pkg::LANE_MASK_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] done_i,
  input  logic             clr_we_i,
  input  logic [LANES-1:0] clr_bits_i,
  output logic [LANES-1:0] pend_o,
  output logic             irq_o
);
  logic [LANES-1:0] done_q;
  logic [LANES-1:0] pend_q;
  logic [LANES-1:0] rise;
  logic [LANES-1:0] clr;

  assign rise = done_i & ~done_q & LANE_MASK;
  assign clr  = clr_we_i ? clr_bits_i : '0;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (LANE_MASK[i]) begin : g_eng
      // idle level is 1, so reset high to avoid a false edge
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          done_q[i] <= 1'b1;
          pend_q[i] <= 1'b0;
        end else begin
          done_q[i] <= done_i[i];
          pend_q[i] <= rise[i] | (pend_q[i] & ~clr[i]);
        end
      end
    end else begin : g_rsv
      assign done_q[i] = 1'b1;
      assign pend_q[i] = 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = |pend_q;
endmodule

// File: rtl/clr_regfile.sv
module clr_regfile #(
  parameter int               LANES     = clr_pkg::LANES_DEF,
  parameter int               DW        = clr_pkg::DW_DEF,
  parameter int               AW        = clr_pkg::AW_DEF,
  parameter logic [LANES-1:0] LANE_MASK = clr_pkg::LANE_MASK_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [LANES-1:0] done_i,
  input  logic [LANES-1:0] pass_i,
  input  logic [LANES-1:0] pend_i,
  output logic             trig_we_o,
  output logic             pend_we_o,
  output logic             gate_hw_o,
  output logic             gate_log_o,
  output logic [LANES-1:0] log_o
);
  import clr_pkg::*;
  localparam int PADW = DW - LANES;

  logic [GATE_W-1:0] gate_q;
  logic [LANES-1:0]  log_q;
  logic              gate_we;
  logic              log_we;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[DW-1:LANES];

  assign trig_we_o = we_i && (addr_i == AW'(ADDR_TRIG));
  assign pend_we_o = we_i && (addr_i == AW'(ADDR_PEND));
  assign gate_we   = we_i && (addr_i == AW'(ADDR_GATE));
  assign log_we    = we_i && (addr_i == AW'(ADDR_LOG)) && gate_q[GATE_LOG_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gate_q <= '0;
    else if (gate_we) gate_q <= wdata_i[GATE_W-1:0];
  end

  // separate reset domain: survives rst_ni
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)     log_q <= '0;
    else if (log_we) log_q <= wdata_i[LANES-1:0] & LANE_MASK;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      AW'(ADDR_ACK):  rdata_o = {{PADW{1'b0}}, done_i & LANE_MASK};
      AW'(ADDR_RES):  rdata_o = {{PADW{1'b0}}, pass_i & LANE_MASK};
      AW'(ADDR_PEND): rdata_o = {{PADW{1'b0}}, pend_i};
      AW'(ADDR_GATE): rdata_o = {{(DW-GATE_W){1'b0}}, gate_q};
      AW'(ADDR_LOG):  rdata_o = {{PADW{1'b0}}, log_q};
      default:        rdata_o = '0;
    endcase
  end

  assign gate_hw_o  = gate_q[GATE_HW_BIT];
  assign gate_log_o = gate_q[GATE_LOG_BIT];
  assign log_o      = log_q;
endmodule

// File: rtl/clr_eng_ctrl.sv
module clr_eng_ctrl #(
  parameter int               LANES     = clr_pkg::LANES_DEF,
  parameter int               DW        = clr_pkg::DW_DEF,
  parameter int               AW        = clr_pkg::AW_DEF,
  parameter logic [LANES-1:0] LANE_MASK = clr_pkg::LANE_MASK_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic             bus_we_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  input  logic [LANES-1:0] hw_trig_i,
  output logic [LANES-1:0] eng_start_o,
  input  logic [LANES-1:0] eng_done_i,
  input  logic [LANES-1:0] eng_pass_i,
  output logic             irq_o
);
  logic             trig_we;
  logic             pend_we;
  logic             gate_hw;
  logic             gate_log;
  logic [LANES-1:0] pend;
  logic [LANES-1:0] err_log;

  clr_regfile #(.LANES(LANES), .DW(DW), .AW(AW), .LANE_MASK(LANE_MASK)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .por_ni     (por_ni),
    .we_i       (bus_we_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .rdata_o    (bus_rdata_o),
    .done_i     (eng_done_i),
    .pass_i     (eng_pass_i),
    .pend_i     (pend),
    .trig_we_o  (trig_we),
    .pend_we_o  (pend_we),
    .gate_hw_o  (gate_hw),
    .gate_log_o (gate_log),
    .log_o      (err_log)
  );

  clr_start_gen #(.LANES(LANES), .LANE_MASK(LANE_MASK)) u_start (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_we_i   (trig_we),
    .sw_bits_i (bus_wdata_i[LANES-1:0]),
    .hw_trig_i (hw_trig_i),
    .hw_en_i   (gate_hw),
    .done_i    (eng_done_i),
    .start_o   (eng_start_o)
  );

  clr_irq_track #(.LANES(LANES), .LANE_MASK(LANE_MASK)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (eng_done_i),
    .clr_we_i   (pend_we),
    .clr_bits_i (bus_wdata_i[LANES-1:0]),
    .pend_o     (pend),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/clr_eng_ctrl_chk.sv
module clr_eng_ctrl_chk #(
  parameter int               LANES     = clr_pkg::LANES_DEF,
  parameter int               AW        = clr_pkg::AW_DEF,
  parameter logic [LANES-1:0] LANE_MASK = clr_pkg::LANE_MASK_DEF
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             por_ni,
  input logic             bus_we_i,
  input logic [AW-1:0]    bus_addr_i,
  input logic [LANES-1:0] eng_start_o,
  input logic [LANES-1:0] eng_done_i,
  input logic             irq_o,
  input logic             gate_hw_i,
  input logic             gate_log_i,
  input logic [LANES-1:0] err_log_i
);
  import clr_pkg::*;
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  p_start_rsv_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_start_o & ~LANE_MASK) == '0);

  p_start_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (eng_start_o & ~$past(eng_done_i)) == '0);

  p_start_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_start_o != '0) |=> (eng_start_o & $past(eng_start_o)) == '0);

  p_hw_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_hw_i && !(bus_we_i && bus_addr_i == AW'(ADDR_TRIG))) |=> eng_start_o == '0);

  p_rise_irq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && ((eng_done_i & ~$past(eng_done_i) & LANE_MASK) != '0)) |=> irq_o);

  p_log_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    !(bus_we_i && bus_addr_i == AW'(ADDR_LOG) && gate_log_i) |=> $stable(err_log_i));
endmodule

bind clr_eng_ctrl clr_eng_ctrl_chk #(.LANES(LANES), .AW(AW), .LANE_MASK(LANE_MASK)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .por_ni      (por_ni),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .eng_start_o (eng_start_o),
  .eng_done_i  (eng_done_i),
  .irq_o       (irq_o),
  .gate_hw_i   (gate_hw),
  .gate_log_i  (gate_log),
  .err_log_i   (err_log)
);

// File: tb/clr_eng_ctrl_tb_top.sv
module clr_eng_ctrl_tb_top;
  localparam int L = 18;
  localparam logic [L-1:0] M = 18'h334CF;
  localparam logic [31:0] M32 = 32'h0003_34CF;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, por_ni = 1'b0;
  logic bus_we_i = 1'b0;
  logic [2:0] bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0, bus_rdata_o;
  logic [L-1:0] hw_trig_i = '0, eng_start_o, eng_done_i, eng_pass_i;
  logic irq_o;

  // engine model
  logic [L-1:0] m_done = '1, m_pass = '0, m_fin = '0;
  int cnt [L];
  logic fin_clr = 1'b0;
  // manual drive and reserved-lane noise
  logic manual = 1'b0;
  logic [L-1:0] man_done = '1, man_pass = '0, noise = '0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign eng_done_i = ((manual ? man_done : m_done) & M) | (noise & ~M);
  assign eng_pass_i = ((manual ? man_pass : m_pass) & M) | (~noise & ~M);

  clr_eng_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .por_ni(por_ni),
    .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .hw_trig_i(hw_trig_i), .eng_start_o(eng_start_o),
    .eng_done_i(eng_done_i), .eng_pass_i(eng_pass_i), .irq_o(irq_o)
  );

  initial for (int i = 0; i < L; i++) cnt[i] = 0;

  always @(posedge clk) begin
    logic [L-1:0] fin;
    fin = '0;
    for (int i = 0; i < L; i++) begin
      if (M[i] && !manual) begin
        if (eng_start_o[i]) begin
          m_done[i] <= 1'b0;
          cnt[i] <= 2 + int'($urandom % 5);
        end else if (cnt[i] == 1) begin
          m_done[i] <= 1'b1;
          m_pass[i] <= 1'($urandom % 2);
          cnt[i] <= 0;
          fin[i] = 1'b1;
        end else if (cnt[i] > 1) begin
          cnt[i] <= cnt[i] - 1;
        end
      end
    end
    m_fin <= fin_clr ? fin : (m_fin | fin);
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(int a, logic [31:0] d);
    bus_we_i = 1'b1; bus_addr_i = 3'(a); bus_wdata_i = d;
    tick();
    bus_we_i = 1'b0;
  endtask

  task automatic bus_rd(int a, output logic [31:0] d);
    bus_addr_i = 3'(a);
    #1 d = bus_rdata_o;
  endtask

  function automatic logic [31:0] ext(logic [L-1:0] v);
    return {14'b0, v};
  endfunction

  initial begin
    logic [31:0] rd, mask;
    logic [L-1:0] exp_st;
    void'($urandom(32'h5EED_0C1E));
    repeat (3) @(negedge clk);
    por_ni = 1'b1; rst_ni = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 start", ext(eng_start_o), 0);
    chk("R11 irq", {31'b0, irq_o}, 0);
    bus_rd(3, rd); chk("R11 pend", rd, 0);
    bus_rd(4, rd); chk("R11 gate", rd, 0);
    bus_rd(5, rd); chk("R11 log", rd, 0);

    // random phase with engine model
    for (int r = 0; r < 60; r++) begin
      mask = $urandom;
      exp_st = mask[L-1:0] & M & m_done;
      bus_wr(0, mask);
      chk("R1 R9 R10 start", ext(eng_start_o), ext(exp_st));
      noise = L'($urandom);
      bus_rd(1, rd); chk("R2 R9 ack", rd, ext(m_done & M));
      bus_rd(0, rd); chk("R1 trig reads 0", rd, 0);
      repeat (1 + $urandom % 3) tick();
      if (r % 6 == 5) begin
        repeat (12) tick();
        bus_rd(3, rd); chk("R4 pend", rd, ext(m_fin));
        chk("R4 irq", {31'b0, irq_o}, {31'b0, m_fin != '0});
        bus_rd(2, rd); chk("R3 result", rd, ext(m_pass & M));
        fin_clr = 1'b1;
        bus_wr(3, 32'hFFFF_FFFF);
        fin_clr = 1'b0;
        bus_rd(3, rd); chk("R5 pend cleared", rd, 0);
        chk("R5 irq low", {31'b0, irq_o}, 0);
      end
    end
    repeat (12) tick();
    fin_clr = 1'b1; bus_wr(3, 32'hFFFF_FFFF); fin_clr = 1'b0;

    // manual phase
    man_done = '1; manual = 1'b1;
    tick();
    for (int k = 0; k < 4; k++) begin
      man_done = L'($urandom); man_pass = L'($urandom); noise = L'($urandom);
      bus_rd(1, rd); chk("R2 ack pattern", rd, ext(man_done & M));
      bus_rd(2, rd); chk("R3 result pattern", rd, ext(man_pass & M));
      tick();
    end
    man_done = '1; tick();
    bus_wr(3, 32'hFFFF_FFFF);

    // R5 rise and clear in the same cycle
    man_done[0] = 1'b0; tick();
    man_done[0] = 1'b1;
    bus_wr(3, 32'h1);
    bus_rd(3, rd); chk("R5 rise wins", rd, 32'h1);
    chk("R4 irq set", {31'b0, irq_o}, 1);
    bus_wr(3, 32'h0);
    bus_rd(3, rd); chk("R5 write 0 keeps", rd, 32'h1);
    bus_wr(3, 32'h1);
    bus_rd(3, rd); chk("R5 w1c", rd, 0);
    chk("R4 irq clear", {31'b0, irq_o}, 0);

    // R10 busy lane and in-flight pulse
    man_done[1] = 1'b0;
    bus_wr(0, 32'h6);
    chk("R10 busy lane skipped", ext(eng_start_o), 32'h4);
    man_done[1] = 1'b1;
    tick();
    bus_we_i = 1'b1; bus_addr_i = 3'd0; bus_wdata_i = 32'h8;
    tick();
    chk("R10 first pulse", ext(eng_start_o), 32'h8);
    tick();
    bus_we_i = 1'b0;
    chk("R10 no second pulse", ext(eng_start_o), 0);
    tick();

    // R6 hardware trigger gate
    hw_trig_i = L'(1) << 10;
    tick(); chk("R6 gated off", ext(eng_start_o), 0);
    tick(); chk("R6 gated off again", ext(eng_start_o), 0);
    hw_trig_i = '0;
    bus_wr(4, 32'h1);
    bus_rd(4, rd); chk("R6 gate set", rd, 32'h1);
    hw_trig_i = L'(1) << 10;
    tick(); chk("R6 hw start", ext(eng_start_o), 32'h400);
    tick(); chk("R10 hw held no repeat", ext(eng_start_o), 0);
    hw_trig_i = '0;
    tick();
    bus_wr(4, 32'h0);
    hw_trig_i = L'(1) << 12;
    tick(); chk("R6 gate cleared", ext(eng_start_o), 0);
    hw_trig_i = '0;

    // R9 reserved trigger bits
    bus_wr(0, ~M32);
    chk("R9 reserved no start", ext(eng_start_o), 0);

    // R7 log write protection
    bus_wr(5, 32'hFFFF_FFFF);
    bus_rd(5, rd); chk("R7 log protected", rd, 0);
    bus_wr(4, 32'h2);
    bus_wr(5, 32'hFFFF_FFFF);
    bus_rd(5, rd); chk("R7 R9 log written", rd, M32);
    bus_wr(4, 32'hFFFF_FFFF);
    bus_rd(4, rd); chk("R9 gate width", rd, 32'h3);

    // R8 reset domains
    rst_ni = 1'b0; tick(); rst_ni = 1'b1; tick();
    bus_rd(4, rd); chk("R11 gate after rst", rd, 0);
    bus_rd(5, rd); chk("R8 log kept", rd, M32);
    por_ni = 1'b0; rst_ni = 1'b0; tick(); por_ni = 1'b1; rst_ni = 1'b1; tick();
    bus_rd(5, rd); chk("R8 log por", rd, 0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule